// File: doc/BRIEF.md
# External CAM Lookup Sequencer

This block sits behind the receive path of an Ethernet controller that runs in promiscuous mode. It hands every completed frame's destination address to an external content-addressable memory and acts on what comes back. When the receive logic signals that a frame has ended, the sequencer latches the six destination address bytes. It then runs a fixed bus transaction toward the CAM: two 32-bit writes that present the key, followed by one 32-bit read that fetches the result word.

Each access holds its request until the CAM acknowledges it. A programmable limit bounds how long the sequencer waits for that acknowledge. If the top bit of the result word is set, the frame is flagged for rejection. Otherwise the low 16 bits of the result are appended after the frame's last byte as a two-byte tag. If an acknowledge fails to arrive in time, the frame is rejected and an error strobe is raised. The sequencer handles only one lookup at a time.

Top module: `cam_lookup_seq`

## Requirements
- R1: A frame-done strobe starts a lookup only while promiscEn is 1; with promiscEn at 0 the strobe is ignored and camReq stays 0.
- R2: A lookup issues exactly three accesses in this order: a write to camAddr 0, a write to camAddr 1, then a read (camWr = 0) from camAddr 2.
- R3: destAddr[47:40] is address byte 0 and destAddr[7:0] is byte 5. The first write carries bytes 0..3 with byte 0 in bits 31:24. The second write carries bytes 4 and 5 in bits 31:16, and bits 15:0 are zero.
- R4: Once raised, camReq stays high with stable camAddr and camWData until camAck is seen. Accesses run back to back, so with an acknowledge latency of L cycles each access holds camReq for L+1 cycles.
- R5: If bit 31 of the read result is 1, rejectPulse is 1 for one cycle and no tag is emitted.
- R6: If bit 31 of the read result is 0, tagValid is 1 for two consecutive cycles. tagByte carries result bits 7:0 in the first of these cycles and bits 15:8 in the second, and rejectPulse stays 0.
- R7: If an access sees no acknowledge within ackTimeout cycles of its request being raised, camReq falls after exactly ackTimeout cycles. In the next cycle rejectPulse and errPulse are both 1 for one cycle, and the remaining accesses are skipped.
- R8: A frame-done strobe that arrives while busy is 1 is ignored. The running lookup keeps its latched address and no extra lookup follows.
- R9: When frameDone is sampled in cycle 0 and every access is acknowledged with latency L, the outcome appears in cycle 3(L+1)+1. That outcome is either the first tag byte or the reject pulse.
- R10: After reset, camReq, busy, tagValid, rejectPulse and errPulse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| promiscEn | input | 1 | Controller is in promiscuous mode; enables lookups |
| frameDone | input | 1 | One-cycle strobe at the end of a received frame |
| destAddr | input | 48 | Captured destination address, byte 0 in bits 47:40 |
| ackTimeout | input | TMO_W | Maximum cycles an access waits for camAck |
| camReq | output | 1 | CAM access request |
| camWr | output | 1 | 1 for a write access, 0 for the read |
| camAddr | output | 2 | Access index: 0 and 1 key writes, 2 result read |
| camWData | output | 32 | Write data toward the CAM |
| camRData | input | 32 | Read data from the CAM, valid with camAck |
| camAck | input | 1 | CAM acknowledge for the current access |
| busy | output | 1 | A lookup is in progress |
| tagValid | output | 1 | tagByte holds a tag byte this cycle |
| tagByte | output | 8 | Appended tag byte, low byte first |
| rejectPulse | output | 1 | One-cycle strobe: discard the frame |
| errPulse | output | 1 | One-cycle strobe: an access timed out |

## Verification
Results are due on fixed cycles. With frameDone sampled in cycle 0 and acknowledge latency L, each access fills L+1 cycles, and the outcome lands in cycle 3(L+1)+1. On a timeout, the error and reject strobes land in the cycle after the last request cycle. The bench drives stimulus just after a falling edge and restarts its cycle counter there. A single falling-edge monitor records the arrival cycle of every tag byte, reject and error strobe, along with the count of request cycles. Each directed task compares those recorded cycle numbers against the values computed above for its latency and timeout, instead of polling until something happens.

// File: rtl/cam_seq_pkg.sv
package cam_seq_pkg;
  localparam int CAM_DW = 32;
  localparam int TAG_W  = 16;
  localparam int MAC_W  = 48;
  localparam int CAM_AW = 2;

  localparam logic [CAM_AW-1:0] ADR_KEY_HI = 2'd0;
  localparam logic [CAM_AW-1:0] ADR_KEY_LO = 2'd1;
  localparam logic [CAM_AW-1:0] ADR_RESULT = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_KEY_HI, S_KEY_LO, S_FETCH, S_EVAL, S_TAG_HI, S_FAIL
  } seqState_t;

  typedef enum logic [1:0] {
    W_KEY_HI = 2'd0, W_KEY_LO = 2'd1, W_NONE = 2'd2
  } wordSel_t;

  typedef struct packed {
    logic     loadAddr;
    logic     loadResult;
    logic     clrCnt;
    logic     incCnt;
    wordSel_t wordSel;
    logic     tagHi;
  } seqStrobe_t;
endpackage

// File: rtl/cam_seq_dp.sv
module cam_seq_dp
  import cam_seq_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [MAC_W-1:0]    destAddr,
  input  logic [CAM_DW-1:0]   camRData,
  input  logic [TMO_W-1:0]    ackTimeout,
  output logic [CAM_DW-1:0]   camWData,
  output logic [7:0]          tagByte,
  output logic                resRej,
  output logic                timedOut
);
  localparam int TAG_BYTES = TAG_W / 8;
  localparam int HALF_W    = CAM_DW / 2;
  localparam int LO_KEY_W  = MAC_W - CAM_DW;

  logic [MAC_W-1:0] addrReg;
  logic [TAG_W-1:0] tagReg;
  logic             rejReg;
  logic [TMO_W-1:0] waitCnt;
  logic [TMO_W:0]   waitNext;
  logic [7:0]       tagLane [TAG_BYTES];
  logic             unusedBits;

  assign unusedBits = ^camRData[CAM_DW-2:TAG_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      tagReg  <= '0;
      rejReg  <= 1'b0;
      waitCnt <= '0;
    end else begin
      if (strobe.loadAddr) addrReg <= destAddr;
      if (strobe.loadResult) begin
        rejReg <= camRData[CAM_DW-1];
        tagReg <= camRData[TAG_W-1:0];
      end
      if (strobe.clrCnt)      waitCnt <= '0;
      else if (strobe.incCnt) waitCnt <= waitCnt + 1'b1;
    end
  end

  assign waitNext = {1'b0, waitCnt} + {{TMO_W{1'b0}}, 1'b1};
  assign timedOut = (waitNext >= {1'b0, ackTimeout});

  always_comb begin
    unique case (strobe.wordSel)
      W_KEY_HI: camWData = addrReg[MAC_W-1 -: CAM_DW];
      W_KEY_LO: camWData = {addrReg[LO_KEY_W-1:0], {(HALF_W){1'b0}}};
      default:  camWData = '0;
    endcase
  end

  for (genvar b = 0; b < TAG_BYTES; b++) begin : g_lane
    assign tagLane[b] = tagReg[8*b +: 8];
  end

  assign tagByte = tagLane[strobe.tagHi];
  assign resRej  = rejReg;
endmodule

// File: rtl/cam_seq_ctrl.sv
module cam_seq_ctrl
  import cam_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              promiscEn,
  input  logic              frameDone,
  input  logic              camAck,
  input  logic              resRej,
  input  logic              timedOut,
  output seqStrobe_t        strobe,
  output logic              camReq,
  output logic              camWr,
  output logic [CAM_AW-1:0] camAddr,
  output logic              busy,
  output logic              tagValid,
  output logic              rejectPulse,
  output logic              errPulse
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strobe      = '{loadAddr: 1'b0, loadResult: 1'b0, clrCnt: 1'b0,
                    incCnt: 1'b0, wordSel: W_NONE, tagHi: 1'b0};
    camReq      = 1'b0;
    camWr       = 1'b0;
    camAddr     = ADR_KEY_HI;
    tagValid    = 1'b0;
    rejectPulse = 1'b0;
    errPulse    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (frameDone && promiscEn) begin
          strobe.loadAddr = 1'b1;
          strobe.clrCnt   = 1'b1;
          nextState       = S_KEY_HI;
        end
      end
      S_KEY_HI, S_KEY_LO: begin
        camReq         = 1'b1;
        camWr          = 1'b1;
        camAddr        = (state == S_KEY_HI) ? ADR_KEY_HI : ADR_KEY_LO;
        strobe.wordSel = (state == S_KEY_HI) ? W_KEY_HI : W_KEY_LO;
        if (camAck) begin
          strobe.clrCnt = 1'b1;
          nextState     = (state == S_KEY_HI) ? S_KEY_LO : S_FETCH;
        end else if (timedOut) begin
          nextState = S_FAIL;
        end else begin
          strobe.incCnt = 1'b1;
        end
      end
      S_FETCH: begin
        camReq  = 1'b1;
        camAddr = ADR_RESULT;
        if (camAck) begin
          strobe.loadResult = 1'b1;
          strobe.clrCnt     = 1'b1;
          nextState         = S_EVAL;
        end else if (timedOut) begin
          nextState = S_FAIL;
        end else begin
          strobe.incCnt = 1'b1;
        end
      end
      S_EVAL: begin
        if (resRej) begin
          rejectPulse = 1'b1;
          nextState   = S_IDLE;
        end else begin
          tagValid  = 1'b1;
          nextState = S_TAG_HI;
        end
      end
      S_TAG_HI: begin
        tagValid     = 1'b1;
        strobe.tagHi = 1'b1;
        nextState    = S_IDLE;
      end
      S_FAIL: begin
        rejectPulse = 1'b1;
        errPulse    = 1'b1;
        nextState   = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/cam_lookup_seq.sv
module cam_lookup_seq
  import cam_seq_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              promiscEn,
  input  logic              frameDone,
  input  logic [MAC_W-1:0]  destAddr,
  input  logic [TMO_W-1:0]  ackTimeout,
  output logic              camReq,
  output logic              camWr,
  output logic [CAM_AW-1:0] camAddr,
  output logic [CAM_DW-1:0] camWData,
  input  logic [CAM_DW-1:0] camRData,
  input  logic              camAck,
  output logic              busy,
  output logic              tagValid,
  output logic [7:0]        tagByte,
  output logic              rejectPulse,
  output logic              errPulse
);
  seqStrobe_t strobe;
  logic       resRej;
  logic       timedOut;

  cam_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .promiscEn(promiscEn), .frameDone(frameDone),
    .camAck(camAck), .resRej(resRej), .timedOut(timedOut), .strobe(strobe),
    .camReq(camReq), .camWr(camWr), .camAddr(camAddr), .busy(busy),
    .tagValid(tagValid), .rejectPulse(rejectPulse), .errPulse(errPulse)
  );

  cam_seq_dp #(.TMO_W(TMO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .destAddr(destAddr),
    .camRData(camRData), .ackTimeout(ackTimeout), .camWData(camWData),
    .tagByte(tagByte), .resRej(resRej), .timedOut(timedOut)
  );
endmodule

// File: rtl/cam_seq_chk.sv
module cam_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        promiscEn,
  input logic        frameDone,
  input logic        camReq,
  input logic        camWr,
  input logic [1:0]  camAddr,
  input logic [31:0] camWData,
  input logic        camAck,
  input logic        busy,
  input logic        tagValid,
  input logic        rejectPulse,
  input logic        errPulse
);
  p_idle_no_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !camReq);

  p_start_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(frameDone && promiscEn)) |=> !busy);

  p_read_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (camReq && !camWr) |-> (camAddr == 2'd2));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (camReq && !camAck) |=> (camReq || errPulse));

  p_req_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (camReq && !camAck) |=> (!camReq || ($stable(camAddr) && $stable(camWData))));

  p_no_tag_on_reject_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(rejectPulse && tagValid));

  p_tag_pair_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tagValid && !$past(tagValid)) |=> tagValid);

  p_tag_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tagValid && $past(tagValid)) |=> !tagValid);

  p_err_rejects_r7: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> rejectPulse);

  p_err_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);
endmodule

bind cam_lookup_seq cam_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .promiscEn(promiscEn), .frameDone(frameDone),
  .camReq(camReq), .camWr(camWr), .camAddr(camAddr), .camWData(camWData),
  .camAck(camAck), .busy(busy), .tagValid(tagValid),
  .rejectPulse(rejectPulse), .errPulse(errPulse)
);

// File: tb/cam_lookup_seq_bench.sv
`timescale 1ns/1ps
module cam_lookup_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        promiscEn = 1'b1;
  logic        frameDone = 1'b0;
  logic [47:0] destAddr = '0;
  logic [15:0] ackTimeout = 16'd100;
  logic        camReq, camWr, busy, tagValid, rejectPulse, errPulse;
  logic [1:0]  camAddr;
  logic [31:0] camWData;
  logic [31:0] camRData = '0;
  logic        camAck = 1'b0;
  logic [7:0]  tagByte;

  int nChecks = 0, nErr = 0;
  bit finished = 0;

  int lat = 0, latCnt = 0, ackBudget = 0;
  int cyc = 0, reqCycles = 0, accN = 0, tagN = 0;
  int tagFirstAt = 0, rejN = 0, rejAt = 0, errN = 0, errAt = 0;
  logic        accWr   [8];
  logic [1:0]  accAddr [8];
  logic [31:0] accData [8];
  logic [7:0]  tagLog  [4];

  always #5 clk = ~clk;

  cam_lookup_seq u_cam_lookup_seq (
    .clk(clk), .rstN(rstN), .promiscEn(promiscEn), .frameDone(frameDone),
    .destAddr(destAddr), .ackTimeout(ackTimeout), .camReq(camReq),
    .camWr(camWr), .camAddr(camAddr), .camWData(camWData),
    .camRData(camRData), .camAck(camAck), .busy(busy), .tagValid(tagValid),
    .tagByte(tagByte), .rejectPulse(rejectPulse), .errPulse(errPulse)
  );

  // Monitor and CAM model, both on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (camReq) reqCycles++;
    if (tagValid) begin
      if (tagN < 4) tagLog[tagN] = tagByte;
      if (tagN == 0) tagFirstAt = cyc;
      tagN++;
    end
    if (rejectPulse) begin rejN++; rejAt = cyc; end
    if (errPulse) begin errN++; errAt = cyc; end
    camAck = 1'b0;
    if (camReq && ackBudget > 0) begin
      if (latCnt == lat) begin
        camAck = 1'b1;
        latCnt = 0;
        ackBudget--;
        if (accN < 8) begin
          accWr[accN] = camWr; accAddr[accN] = camAddr; accData[accN] = camWData;
        end
        accN++;
      end else begin
        latCnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [47:0] dest, input int latency, input int budget);
    @(negedge clk); #1;
    cyc = 0; reqCycles = 0; accN = 0; tagN = 0; tagFirstAt = 0;
    rejN = 0; rejAt = 0; errN = 0; errAt = 0; latCnt = 0;
    lat = latency; ackBudget = budget; destAddr = dest; frameDone = 1'b1;
    @(negedge clk); #1;
    frameDone = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R10 camReq", camReq, 0);
    chk("R10 busy", busy, 0);
    chk("R10 tagValid", tagValid, 0);
    chk("R10 rejectPulse", rejectPulse, 0);
    chk("R10 errPulse", errPulse, 0);
  endtask

  task automatic t_accept();
    camRData = 32'h7FFF_A5C3;
    fire(48'h0123_4567_89AB, 0, 3);
    settle();
    chk("R2 access count", accN, 3);
    chk("R2 access0 write", accWr[0], 1);
    chk("R2 access0 addr", accAddr[0], 0);
    chk("R2 access1 write", accWr[1], 1);
    chk("R2 access1 addr", accAddr[1], 1);
    chk("R2 access2 read", accWr[2], 0);
    chk("R2 access2 addr", accAddr[2], 2);
    chk("R3 key word hi", accData[0], 32'h0123_4567);
    chk("R3 key word lo", accData[1], 32'h89AB_0000);
    chk("R6 tag bytes", tagN, 2);
    chk("R6 tag low", tagLog[0], 8'hC3);
    chk("R6 tag high", tagLog[1], 8'hA5);
    chk("R6 no reject", rejN, 0);
    chk("R9 tag cycle L0", tagFirstAt, 4);
    chk("R4 req cycles L0", reqCycles, 3);
  endtask

  task automatic t_reject();
    camRData = 32'h8000_1234;
    fire(48'hFFEE_DDCC_BBAA, 2, 3);
    settle();
    chk("R5 reject count", rejN, 1);
    chk("R5 no tag", tagN, 0);
    chk("R5 no error", errN, 0);
    chk("R9 reject cycle L2", rejAt, 10);
  endtask

  task automatic t_latency();
    camRData = 32'h0000_5A01;
    fire(48'h1122_3344_5566, 3, 3);
    settle();
    chk("R4 req cycles L3", reqCycles, 12);
    chk("R9 tag cycle L3", tagFirstAt, 13);
    chk("R3 key word lo L3", accData[1], 32'h5566_0000);
    chk("R6 tag low L3", tagLog[0], 8'h01);
  endtask

  task automatic t_timeout_first();
    ackTimeout = 16'd5;
    fire(48'hA0A1_A2A3_A4A5, 0, 0);
    settle();
    chk("R7 req cycles", reqCycles, 5);
    chk("R7 error count", errN, 1);
    chk("R7 reject count", rejN, 1);
    chk("R7 error cycle", errAt, 6);
    chk("R7 no tag", tagN, 0);
    ackTimeout = 16'd100;
  endtask

  task automatic t_timeout_second();
    ackTimeout = 16'd3;
    camRData = 32'h0000_0000;
    fire(48'hB0B1_B2B3_B4B5, 0, 1);
    settle();
    chk("R7 accesses before stall", accN, 1);
    chk("R7 req cycles 2nd", reqCycles, 4);
    chk("R7 error cycle 2nd", errAt, 5);
    chk("R7 no tag 2nd", tagN, 0);
    ackTimeout = 16'd100;
  endtask

  task automatic t_busy_ignore();
    camRData = 32'h0000_7E3C;
    fire(48'hC0C1_C2C3_C4C5, 1, 6);
    @(negedge clk); #1;
    destAddr = 48'hDEAD_BEEF_0000;
    frameDone = 1'b1;
    @(negedge clk); #1;
    frameDone = 1'b0;
    settle();
    chk("R8 access count", accN, 3);
    chk("R8 latched key", accData[0], 32'hC0C1_C2C3);
    chk("R8 single tag pair", tagN, 2);
    chk("R8 idle after", busy, 0);
  endtask

  task automatic t_promisc_off();
    promiscEn = 1'b0;
    fire(48'h0102_0304_0506, 0, 3);
    settle();
    chk("R1 no request", reqCycles, 0);
    chk("R1 no access", accN, 0);
    chk("R1 stays idle", busy, 0);
    promiscEn = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_accept();
    t_reject();
    t_latency();
    t_timeout_first();
    t_timeout_second();
    t_busy_ignore();
    t_promisc_off();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule